// File: doc/BRIEF.md
# Prefix Real-to-Absolute Translator

This block keeps the per-processor prefix value and turns each 64-bit real address into an absolute address. It works on 8 KiB areas, each made of two 4 KiB pages. Real area zero is swapped with the area that the prefix names. Any real address inside the prefixed area goes back to absolute area zero. Every other address comes out unchanged. The low 13 bits, which give the offset inside an area, are never altered.

Bits are numbered big-endian, so architectural bit 0 is vector bit 63. The prefix can only be nonzero in vector bits 30 down to 13, which are architectural bits 33 to 50. Software loads the prefix through a write strobe and can read it back at any time. Translation runs as a pipeline with one register stage. A valid real address presented on one edge gives its absolute address, and a code naming the mapping case, right after that edge.

Top module: `prefix_xlate`

## Requirements
- R1: After reset, `pfx_value` is zero, `out_valid` is 0, `out_abs` is zero and `out_kind` is 0.
- R2: A prefix load stores `pfx_wr_data` masked to vector bits 30..13 (mask 0x0000_0000_7FFF_E000). Every other bit is ignored and reads back as zero on `pfx_value` from the cycle after the strobe.
- R3: When vector bits 63..13 of the real address are all zero, the absolute address is the prefix with the real offset bits 12..0 inserted, and `out_kind` is 1 (swapped to prefix).
- R4: When bits 63..13 of the real address equal bits 63..13 of a nonzero prefix, those bits become zero, the offset is kept, and `out_kind` is 2 (swapped to zero).
- R5: In every other case the absolute address equals the real address and `out_kind` is 0 (unchanged).
- R6: Bits 12..0 of `out_abs` always equal bits 12..0 of the real address that produced it.
- R7: With a zero prefix, a real address in area zero maps to itself and reports `out_kind` 1, because the zero-area case takes priority.
- R8: `out_valid` equals `xl_valid` delayed by exactly one clock. A result appears on the edge that samples its real address.
- R9: A translation sampled on the same edge as a prefix load uses the old prefix. A translation on the next edge uses the new prefix.
- R10: While `xl_valid` is low, `out_abs` and `out_kind` hold their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| pfx_wr_en | input | 1 | Prefix load strobe |
| pfx_wr_data | input | 64 | New prefix value; bits outside 30..13 are ignored |
| pfx_value | output | 64 | Current prefix |
| xl_valid | input | 1 | Real address valid |
| xl_real | input | 64 | Real address |
| out_valid | output | 1 | Result valid, one cycle after `xl_valid` |
| out_abs | output | 64 | Absolute address |
| out_kind | output | 2 | 0 unchanged, 1 swapped to prefix, 2 swapped to zero |

## Verification
The properties assume that `xl_valid`, `pfx_wr_en` and their data buses are at defined levels on every sampled edge, and that the inputs stay quiet while reset is held. The bench drives every input only on falling edges and keeps them all at zero through reset. The zero-area check and the hold check each compare against values from the previous edge, so the only stimulus they need is valid inputs on the edge before each result. The bench covers both the prefix-zero case and the case where a load and a translation share an edge.

// File: rtl/prefix_xlate_pkg.sv
package prefix_xlate_pkg;

  typedef enum logic [1:0] {
    KIND_PASS    = 2'd0,
    KIND_TO_PFX  = 2'd1,
    KIND_TO_ZERO = 2'd2
  } map_kind_e;

endpackage

// File: rtl/pfx_reg.sv
module pfx_reg #(
  parameter int ADDR_W = 64,
  parameter int AREA_W = 13,
  parameter int PFX_W  = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_data,
  output logic [ADDR_W-1:0] pfx_q
);

  // Ones over the bits a prefix may occupy: [PFX_W-1 : AREA_W]
  function automatic logic [ADDR_W-1:0] field_mask();
    logic [ADDR_W-1:0] upper;
    logic [ADDR_W-1:0] lower;
    upper = (ADDR_W'(1) << PFX_W) - ADDR_W'(1);
    lower = (ADDR_W'(1) << AREA_W) - ADDR_W'(1);
    return upper & ~lower;
  endfunction

  localparam logic [ADDR_W-1:0] MASK = field_mask();

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pfx_q <= '0;
    else if (wr_en) pfx_q <= wr_data & MASK;
  end

endmodule

// File: rtl/pfx_match.sv
module pfx_match
  import prefix_xlate_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int AREA_W = 13
) (
  input  logic [ADDR_W-1:0] real_addr,
  input  logic [ADDR_W-1:0] pfx,
  output logic              hit_low,
  output logic              hit_pfx,
  output map_kind_e         kind,
  output logic [ADDR_W-1:0] abs_addr
);

  localparam int PG_W = ADDR_W - AREA_W;

  function automatic logic [PG_W-1:0] page_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:AREA_W];
  endfunction

  function automatic logic [AREA_W-1:0] offset_of(input logic [ADDR_W-1:0] a);
    return a[AREA_W-1:0];
  endfunction

  logic [PG_W-1:0] real_pg;
  logic [PG_W-1:0] pfx_pg;
  logic [PG_W-1:0] abs_pg;

  assign real_pg = page_of(real_addr);
  assign pfx_pg  = page_of(pfx);
  assign hit_low = (real_pg == '0);
  assign hit_pfx = (real_pg == pfx_pg);

  // Zero area has priority, so a zero prefix maps area zero onto itself
  always_comb begin
    if (hit_low) begin
      kind   = KIND_TO_PFX;
      abs_pg = pfx_pg;
    end else if (hit_pfx) begin
      kind   = KIND_TO_ZERO;
      abs_pg = '0;
    end else begin
      kind   = KIND_PASS;
      abs_pg = real_pg;
    end
  end

  assign abs_addr = {abs_pg, offset_of(real_addr)};

endmodule

// File: rtl/pfx_out_stage.sv
module pfx_out_stage
  import prefix_xlate_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [ADDR_W-1:0] in_abs,
  input  map_kind_e         in_kind,
  output logic              out_valid,
  output logic [ADDR_W-1:0] out_abs,
  output map_kind_e         out_kind
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= in_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_abs  <= '0;
      out_kind <= KIND_PASS;
    end else if (in_valid) begin
      out_abs  <= in_abs;
      out_kind <= in_kind;
    end
  end

endmodule

// File: rtl/prefix_xlate.sv
module prefix_xlate
  import prefix_xlate_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int AREA_W = 13,
  parameter int PFX_W  = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pfx_wr_en,
  input  logic [ADDR_W-1:0] pfx_wr_data,
  output logic [ADDR_W-1:0] pfx_value,
  input  logic              xl_valid,
  input  logic [ADDR_W-1:0] xl_real,
  output logic              out_valid,
  output logic [ADDR_W-1:0] out_abs,
  output logic [1:0]        out_kind
);

  logic [ADDR_W-1:0] pfx_q;
  logic              hit_low;
  logic              hit_pfx;
  map_kind_e         comb_kind;
  logic [ADDR_W-1:0] comb_abs;
  map_kind_e         reg_kind;

  pfx_reg #(.ADDR_W(ADDR_W), .AREA_W(AREA_W), .PFX_W(PFX_W)) u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (pfx_wr_en),
    .wr_data (pfx_wr_data),
    .pfx_q   (pfx_q)
  );

  pfx_match #(.ADDR_W(ADDR_W), .AREA_W(AREA_W)) u_match (
    .real_addr (xl_real),
    .pfx       (pfx_q),
    .hit_low   (hit_low),
    .hit_pfx   (hit_pfx),
    .kind      (comb_kind),
    .abs_addr  (comb_abs)
  );

  pfx_out_stage #(.ADDR_W(ADDR_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (xl_valid),
    .in_abs    (comb_abs),
    .in_kind   (comb_kind),
    .out_valid (out_valid),
    .out_abs   (out_abs),
    .out_kind  (reg_kind)
  );

  assign pfx_value = pfx_q;
  assign out_kind  = reg_kind;

endmodule

// File: rtl/prefix_xlate_chk.sv
module prefix_xlate_chk #(
  parameter int ADDR_W = 64,
  parameter int AREA_W = 13,
  parameter int PFX_W  = 31
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pfx_wr_en,
  input logic [ADDR_W-1:0] pfx_wr_data,
  input logic [ADDR_W-1:0] pfx_value,
  input logic              xl_valid,
  input logic [ADDR_W-1:0] xl_real,
  input logic              out_valid,
  input logic [ADDR_W-1:0] out_abs,
  input logic [1:0]        out_kind,
  input logic              hit_low,
  input logic              hit_pfx
);

  localparam logic [ADDR_W-1:0] KEEP =
    ((ADDR_W'(1) << PFX_W) - ADDR_W'(1)) & ~((ADDR_W'(1) << AREA_W) - ADDR_W'(1));

  p_reset_r1: assert property (@(posedge clk) !rst_n |=> (rst_n || (pfx_value == '0 && !out_valid)));

  p_load_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pfx_wr_en |=> pfx_value == ($past(pfx_wr_data) & KEEP));

  p_no_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !pfx_wr_en |=> $stable(pfx_value));

  p_low_area_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (xl_valid && xl_real[ADDR_W-1:AREA_W] == '0) |=>
      (out_kind == 2'd1 && out_abs == ($past(pfx_value) | {{(ADDR_W-AREA_W){1'b0}}, $past(xl_real[AREA_W-1:0])})));

  p_to_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    xl_valid |=> (out_kind != 2'd2 || out_abs[ADDR_W-1:AREA_W] == '0));

  p_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
    xl_valid |=> (out_kind != 2'd0 || out_abs == $past(xl_real)));

  p_offset_r6: assert property (@(posedge clk) disable iff (!rst_n)
    xl_valid |=> out_abs[AREA_W-1:0] == $past(xl_real[AREA_W-1:0]));

  p_both_hits_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_low && hit_pfx) |-> pfx_value == '0);

  p_valid_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    xl_valid |=> out_valid);

  p_valid_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !xl_valid |=> !out_valid);

  p_kind_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_kind != 2'd3);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !xl_valid |=> ($stable(out_abs) && $stable(out_kind)));

endmodule

bind prefix_xlate prefix_xlate_chk #(.ADDR_W(ADDR_W), .AREA_W(AREA_W), .PFX_W(PFX_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pfx_wr_en   (pfx_wr_en),
  .pfx_wr_data (pfx_wr_data),
  .pfx_value   (pfx_value),
  .xl_valid    (xl_valid),
  .xl_real     (xl_real),
  .out_valid   (out_valid),
  .out_abs     (out_abs),
  .out_kind    (out_kind),
  .hit_low     (hit_low),
  .hit_pfx     (hit_pfx)
);

// File: tb/prefix_xlate_test.sv
`timescale 1ns/1ps
module prefix_xlate_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pfx_wr_en = 1'b0;
  logic [63:0] pfx_wr_data = '0;
  logic [63:0] pfx_value;
  logic        xl_valid = 1'b0;
  logic [63:0] xl_real = '0;
  logic        out_valid;
  logic [63:0] out_abs;
  logic [1:0]  out_kind;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  logic [63:0] model_pfx = '0;

  always #10 clk = ~clk;

  prefix_xlate uut (
    .clk(clk), .rst_n(rst_n), .pfx_wr_en(pfx_wr_en), .pfx_wr_data(pfx_wr_data),
    .pfx_value(pfx_value), .xl_valid(xl_valid), .xl_real(xl_real),
    .out_valid(out_valid), .out_abs(out_abs), .out_kind(out_kind)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Reference: divide by the 8 KiB area size instead of slicing bits
  function automatic logic [63:0] ref_abs(input logic [63:0] r, input logic [63:0] p);
    logic [63:0] area_r = r / 64'd8192;
    logic [63:0] area_p = p / 64'd8192;
    logic [63:0] ofs = r % 64'd8192;
    if (area_r == 0) return area_p * 64'd8192 + ofs;
    if (area_r == area_p) return ofs;
    return r;
  endfunction

  function automatic logic [63:0] ref_kind(input logic [63:0] r, input logic [63:0] p);
    if (r / 64'd8192 == 0) return 64'd1;
    if (r / 64'd8192 == p / 64'd8192) return 64'd2;
    return 64'd0;
  endfunction

  task automatic load_pfx(input logic [63:0] d);
    @(negedge clk);
    pfx_wr_en = 1'b1; pfx_wr_data = d;
    @(negedge clk);
    pfx_wr_en = 1'b0; pfx_wr_data = '0;
    model_pfx = d & 64'h0000_0000_7FFF_E000;
  endtask

  task automatic xlate(input string req, input logic [63:0] r);
    @(negedge clk);
    xl_valid = 1'b1; xl_real = r;
    @(negedge clk);
    xl_valid = 1'b0; xl_real = '0;
    chk({req, " valid"}, {63'd0, out_valid}, 64'd1);
    chk({req, " abs"}, out_abs, ref_abs(r, model_pfx));
    chk({req, " kind"}, {62'd0, out_kind}, ref_kind(r, model_pfx));
  endtask

  task automatic t_reset();
    chk("R1 prefix", pfx_value, 64'd0);
    chk("R1 valid", {63'd0, out_valid}, 64'd0);
    chk("R1 abs", out_abs, 64'd0);
    chk("R1 kind", {62'd0, out_kind}, 64'd0);
  endtask

  task automatic t_load_mask();
    load_pfx(64'hFFFF_0000_0012_5ABC);
    chk("R2 masked readback", pfx_value, 64'h0000_0000_0012_4000);
    load_pfx(64'hFFFF_FFFF_FFFF_FFFF);
    chk("R2 all ones", pfx_value, 64'h0000_0000_7FFF_E000);
    load_pfx(64'h0000_0000_0012_4000);
  endtask

  task automatic t_zero_area();
    xlate("R3 low offset", 64'h0000_0000_0000_0ABC);
    chk("R3 value", out_abs, 64'h0000_0000_0012_4ABC);
    xlate("R3 top offset", 64'h0000_0000_0000_1FFF);
    chk("R6 offset kept", out_abs, 64'h0000_0000_0012_5FFF);
  endtask

  task automatic t_prefix_area();
    xlate("R4 prefix area", 64'h0000_0000_0012_5123);
    chk("R4 value", out_abs, 64'h0000_0000_0000_1123);
    chk("R4 kind", {62'd0, out_kind}, 64'd2);
  endtask

  task automatic t_other();
    xlate("R5 area one", 64'h0000_0000_0000_2000);
    xlate("R5 after prefix", 64'h0000_0000_0012_6000);
    xlate("R5 high alias", 64'h8000_0000_0012_4000);
    chk("R5 alias kind", {62'd0, out_kind}, 64'd0);
    xlate("R5 all ones", 64'hFFFF_FFFF_FFFF_FFFF);
  endtask

  task automatic t_prefix_zero();
    load_pfx(64'd0);
    xlate("R7 self map", 64'h0000_0000_0000_0777);
    chk("R7 value", out_abs, 64'h0000_0000_0000_0777);
    chk("R7 kind", {62'd0, out_kind}, 64'd1);
  endtask

  task automatic t_same_cycle();
    load_pfx(64'h0000_0000_0000_8000);
    @(negedge clk);
    pfx_wr_en = 1'b1; pfx_wr_data = 64'h0000_0000_0040_0000;
    xl_valid = 1'b1; xl_real = 64'h0000_0000_0000_0123;
    @(negedge clk);
    pfx_wr_en = 1'b0;
    chk("R9 old prefix", out_abs, 64'h0000_0000_0000_8123);
    @(negedge clk);
    xl_valid = 1'b0; xl_real = '0;
    chk("R9 new prefix", out_abs, 64'h0000_0000_0040_0123);
    chk("R8 valid drop pending", {63'd0, out_valid}, 64'd1);
    model_pfx = 64'h0000_0000_0040_0000;
  endtask

  task automatic t_hold();
    logic [63:0] keep;
    xlate("R10 seed", 64'h0000_0000_0040_1F00);
    keep = out_abs;
    @(negedge clk);
    xl_real = 64'h0000_0000_0000_0055;
    chk("R8 no valid", {63'd0, out_valid}, 64'd0);
    @(negedge clk);
    chk("R10 abs held", out_abs, keep);
    chk("R10 kind held", {62'd0, out_kind}, 64'd2);
    xl_real = '0;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_load_mask();
    t_zero_area();
    t_prefix_area();
    t_other();
    t_prefix_zero();
    t_same_cycle();
    t_hold();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule